// File: doc/BRIEF.md
# Transmit Queue with Ready Thresholds and Frame-Start Gate

This block holds outgoing data in a 64-entry queue of 32-bit double words. Each word carries an end-of-frame mark. A host pushes words in and a MAC-side consumer pulls them out. The consumer sees a word only after the frame it belongs to has been released. A frame is released once enough of it has been loaded, or once its final word arrives. This prevents transmit underruns on large frames and does not stall short ones.

The block also produces two registered handshake flags from an 8-bit threshold byte:

- The receive-ready flag compares an external receive-queue occupancy against the upper nibble plus one.
- The transmit-ready flag compares the free space in the transmit queue against the lower nibble plus one.

A separate 4-bit start value sets the release point of each frame. It is captured when the first word of that frame is written. A small register port writes and reads both settings.

Top module: `txq_threshold_gate`

## Requirements
- R1: `rx_ready` is a registered flag. It is high in the cycle after `rx_level` is at least N+1, and low in the cycle after `rx_level` is at most N. N is bits 7:4 of the threshold byte at `cfg_addr` 0.
- R2: `tx_ready` is high when the free space is at least M+1. Free space is 64 minus the stored word count, and M is bits 3:0 of the threshold byte. The flag follows a change in occupancy two clock edges after the write or read that caused it.
- R3: With a start value S of 1 to 15 (bits 3:0 at `cfg_addr` 1), `mac_avail` stays low for a frame that is still loading until at least 2×S of its words have been written. It rises right after the edge that accepts word 2×S.
- R4: With S=0, which is the reset value, a loading frame is offered as soon as its first word is stored.
- R5: S is captured when the first word of a frame is written. Later changes to S do not move that frame's release point. A frame, once released, stays offered while it has words in the queue.
- R6: Writing a word with `host_wr_last`=1 releases its frame at once, even if fewer than 2×S words were written.
- R7: The following are ignored and leave the stored contents unchanged:
  - a write while the queue holds 64 words;
  - `mac_rd_en` while `mac_avail` is low.

  A write and a read accepted in the same cycle leave the word count unchanged.
- R8: A read at `cfg_addr` 0 returns the threshold byte as written. A read at `cfg_addr` 1 returns 4'hA in bits 7:4 and S in bits 3:0; written bits 7:4 are dropped there. After reset the two reads return 8'h00 and 8'hA0.
- R9: Words leave in the order written. Each `mac_rd_data` and `mac_rd_last` pair is presented before it is popped, and matches the written data and end mark. After reset `mac_avail` and `rx_ready` are low and `tx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Push one word into the queue |
| host_wr_data | input | 32 | Word to push |
| host_wr_last | input | 1 | Pushed word ends its frame |
| mac_rd_en | input | 1 | Pop the presented word (taken only while mac_avail is high) |
| mac_avail | output | 1 | A released word is presented |
| mac_rd_data | output | 32 | Presented word |
| mac_rd_last | output | 1 | Presented word ends its frame |
| rx_level | input | 7 | Receive queue occupancy in double words |
| rx_ready | output | 1 | Receive occupancy reached N+1 |
| tx_ready | output | 1 | Transmit free space reached M+1 |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 selects the threshold byte, 1 selects the start value |
| cfg_wr_data | input | 8 | Register write data |
| cfg_rd_data | output | 8 | Register read data for cfg_addr |

## Verification
The start gate is tried with four loading patterns:

- a single word with S=0;
- a frame that crosses exactly 2×S words, which separates a threshold of 2×S from one of S or 2×S−1;
- a frame whose S is lowered and then raised while it loads, which shows whether S is captured at the first word;
- a short frame closed by its end mark under S=15.

The flags are walked through a table of threshold and occupancy pairs that sit on either side of N+1. The transmit side fills to exactly 16 and 15 free spaces. Full-queue writes, reads of an empty queue and a simultaneous push and pop are told apart by the word sequence drained afterwards.

// File: rtl/txq_pkg.sv
// Package: shared constants and helpers for the transmit queue block.
// Assumes: start values are 4 bits; the release point is at most 30 words.
package txq_pkg;
    localparam int START_W  = 4;
    localparam int NEED_W   = 6;
    localparam logic [3:0] START_ID_NIBBLE = 4'hA;
    localparam logic CFG_SEL_THR   = 1'b0;
    localparam logic CFG_SEL_START = 1'b1;

    // Words a loading frame needs before release: 1 for S=0, else 2*S.
    function automatic logic [NEED_W-1:0] start_need(input logic [START_W-1:0] s);
        if (s == '0) return NEED_W'(1);
        return {1'b0, s, 1'b0};
    endfunction
endpackage

// File: rtl/txq_store.sv
// Module: txq_store
// Circular word storage with end-of-frame marks. Output is shown ahead.
// Assumes: the caller gates rd_en with the frame-release state; writes when
// full and reads when empty are dropped here.
module txq_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_last,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last,
    output logic              wr_ok,
    output logic              rd_ok,
    output logic              empty,
    output logic [CNT_W-1:0]  count
);
    logic [DATA_W:0]  mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             full;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign wr_ok   = wr_en && !full;
    assign rd_ok   = rd_en && !empty;
    assign rd_data = mem[rd_ptr][DATA_W-1:0];
    assign rd_last = mem[rd_ptr][DATA_W];

    // Next pointer position with wrap at DEPTH.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage array write; not reset.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= {wr_last, wr_data};
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= bump(wr_ptr);
            if (rd_ok) rd_ptr <= bump(rd_ptr);
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R7
    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> $stable(count)); // R7
    AST_EMPTY_READ_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en) |=> $stable(count)); // R7
endmodule

// File: rtl/txq_start_gate.sv
// Module: txq_start_gate
// Decides whether the head word may be offered to the MAC side. Complete
// frames are always offered. The frame still loading is offered once its
// word count reaches the release point captured at its first word, or once
// its end mark is written.
// Assumes: push/pop are accepted transfers from the storage.
module txq_start_gate #(
    parameter int CNT_W = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [txq_pkg::START_W-1:0] start_val,
    input  logic                        push,
    input  logic                        push_last,
    input  logic                        pop,
    input  logic                        pop_last,
    input  logic                        empty,
    output logic                        avail
);
    import txq_pkg::*;

    localparam int CMP_W = (CNT_W > NEED_W) ? CNT_W : NEED_W;

    logic [CNT_W-1:0]  load_cnt;
    logic [CNT_W-1:0]  frames_q;
    logic [NEED_W-1:0] need_q;
    logic              part_rel;
    logic [NEED_W-1:0] need_eff;
    logic [CMP_W-1:0]  load_next;

    // Release point: live value at the first word, captured value afterwards.
    always_comb begin
        need_eff  = (load_cnt == '0) ? start_need(start_val) : need_q;
        load_next = CMP_W'(load_cnt) + 1'b1;
    end

    assign avail = !empty && ((frames_q != '0) || part_rel);

    // Loading-frame count, captured release point and release flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_cnt <= '0;
            need_q   <= '0;
            part_rel <= 1'b0;
        end else if (push) begin
            if (push_last) begin
                load_cnt <= '0;
                part_rel <= 1'b0;
            end else begin
                load_cnt <= load_cnt + 1'b1;
                if (load_cnt == '0) need_q <= need_eff;
                if (load_next >= CMP_W'(need_eff)) part_rel <= 1'b1;
            end
        end
    end

    // Number of complete frames held in storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frames_q <= '0;
        end else begin
            case ({push && push_last, pop && pop_last})
                2'b10:   frames_q <= frames_q + 1'b1;
                2'b01:   frames_q <= frames_q - 1'b1;
                default: frames_q <= frames_q;
            endcase
        end
    end

    AST_RELEASE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (part_rel && !(push && push_last)) |=> part_rel); // R5
    AST_LAST_POP_IS_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && pop_last) |-> (frames_q != '0)); // R9
endmodule

// File: rtl/txq_ready_flags.sv
// Module: txq_ready_flags
// Registered receive-ready and transmit-ready flags from the threshold byte.
// Each nibble n encodes a level of n+1 double words.
// Assumes: tx_count is the registered storage occupancy.
module txq_ready_flags #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 7,
    parameter int RXL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       thr,
    input  logic [RXL_W-1:0] rx_level,
    input  logic [CNT_W-1:0] tx_count,
    output logic             rx_ready,
    output logic             tx_ready
);
    localparam int FW = CNT_W + 1;
    localparam int RW = ((RXL_W > 4) ? RXL_W : 4) + 1;

    logic [FW-1:0] tx_free;
    logic [FW-1:0] tx_need;
    logic [RW-1:0] rx_need;
    logic          rx_hit, tx_hit;

    // Level comparisons against nibble plus one.
    always_comb begin
        tx_free = FW'(DEPTH) - FW'(tx_count);
        tx_need = FW'(thr[3:0]) + 1'b1;
        rx_need = RW'(thr[7:4]) + 1'b1;
        rx_hit  = RW'(rx_level) >= rx_need;
        tx_hit  = tx_free >= tx_need;
    end

    // Flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_ready <= 1'b0;
            tx_ready <= 1'b0;
        end else begin
            rx_ready <= rx_hit;
            tx_ready <= tx_hit;
        end
    end

    AST_RX_READY_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (RW'(rx_level) < RW'(thr[7:4]) + 1'b1) |=> !rx_ready); // R1
    AST_TX_READY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == CNT_W'(DEPTH)) |=> !tx_ready); // R2
endmodule

// File: rtl/txq_cfg_regs.sv
// Module: txq_cfg_regs
// Holds the threshold byte and the 4-bit start value. The start register
// reads back a fixed identity nibble in its upper half.
// Assumes: single-cycle write strobe; reads are combinational.
module txq_cfg_regs (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_wr_en,
    input  logic                        cfg_addr,
    input  logic [7:0]                  cfg_wr_data,
    output logic [7:0]                  cfg_rd_data,
    output logic [7:0]                  thr_q,
    output logic [txq_pkg::START_W-1:0] start_q
);
    import txq_pkg::*;

    // Register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q   <= '0;
            start_q <= '0;
        end else if (cfg_wr_en) begin
            if (cfg_addr == CFG_SEL_THR) thr_q <= cfg_wr_data;
            else                         start_q <= cfg_wr_data[START_W-1:0];
        end
    end

    // Read multiplexer.
    always_comb begin
        if (cfg_addr == CFG_SEL_START) cfg_rd_data = {START_ID_NIBBLE, start_q};
        else                           cfg_rd_data = thr_q;
    end
endmodule

// File: rtl/txq_threshold_gate.sv
// Module: txq_threshold_gate (top)
// Transmit queue with ready flags and a frame-start gate. Ties the storage,
// the release logic, the flag registers and the settings together.
// Assumes: DEPTH is at least 30 so the largest release point is reachable.
module txq_threshold_gate #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int RXL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic [DATA_W-1:0] host_wr_data,
    input  logic              host_wr_last,
    input  logic              mac_rd_en,
    output logic              mac_avail,
    output logic [DATA_W-1:0] mac_rd_data,
    output logic              mac_rd_last,
    input  logic [RXL_W-1:0]  rx_level,
    output logic              rx_ready,
    output logic              tx_ready,
    input  logic              cfg_wr_en,
    input  logic              cfg_addr,
    input  logic [7:0]        cfg_wr_data,
    output logic [7:0]        cfg_rd_data
);
    import txq_pkg::*;

    logic [7:0]         thr_q;
    logic [START_W-1:0] start_q;
    logic               wr_ok, rd_ok, st_empty, rd_gated;
    logic [CNT_W-1:0]   st_count;

    assign rd_gated = mac_rd_en && mac_avail;

    txq_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .thr_q(thr_q), .start_q(start_q)
    );

    txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(host_wr_en), .wr_data(host_wr_data), .wr_last(host_wr_last),
        .rd_en(rd_gated), .rd_data(mac_rd_data), .rd_last(mac_rd_last),
        .wr_ok(wr_ok), .rd_ok(rd_ok), .empty(st_empty), .count(st_count)
    );

    txq_start_gate #(.CNT_W(CNT_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .start_val(start_q),
        .push(wr_ok), .push_last(host_wr_last),
        .pop(rd_ok), .pop_last(mac_rd_last),
        .empty(st_empty), .avail(mac_avail)
    );

    txq_ready_flags #(.DEPTH(DEPTH), .CNT_W(CNT_W), .RXL_W(RXL_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .thr(thr_q),
        .rx_level(rx_level), .tx_count(st_count),
        .rx_ready(rx_ready), .tx_ready(tx_ready)
    );

    AST_NO_POP_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_rd_en && !mac_avail) |=> $stable(mac_rd_data)); // R7
endmodule

// File: tb/txq_threshold_gate_bench.sv
module txq_threshold_gate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [31:0] host_wr_data = '0;
    logic        host_wr_last = 1'b0;
    logic        mac_rd_en = 1'b0;
    logic        mac_avail;
    logic [31:0] mac_rd_data;
    logic        mac_rd_last;
    logic [6:0]  rx_level = '0;
    logic        rx_ready, tx_ready;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_addr = 1'b0;
    logic [7:0]  cfg_wr_data = '0;
    logic [7:0]  cfg_rd_data;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    txq_threshold_gate u_txq_threshold_gate (.*);

    // Receive-ready table: {N[3:0], rx_level[6:0], expected rx_ready}.
    localparam logic [11:0] RX_VEC [8] = '{
        {4'd0,  7'd0,  1'b0}, {4'd0,  7'd1,  1'b1},
        {4'd3,  7'd3,  1'b0}, {4'd3,  7'd4,  1'b1},
        {4'd15, 7'd15, 1'b0}, {4'd15, 7'd16, 1'b1},
        {4'd7,  7'd64, 1'b1}, {4'd9,  7'd9,  1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic cfg_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rd_data;
    endtask

    task automatic host_write(input logic [31:0] d, input logic last);
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_data = d; host_wr_last = last;
        @(negedge clk);
        host_wr_en = 1'b0; host_wr_last = 1'b0;
    endtask

    task automatic mac_read(output logic [31:0] d, output logic last);
        @(negedge clk);
        d = mac_rd_data; last = mac_rd_last;
        mac_rd_en = 1'b1;
        @(negedge clk);
        mac_rd_en = 1'b0;
    endtask

    task automatic expect_word(input string tag, input logic [31:0] d, input logic last);
        logic [31:0] got;
        logic        gl;
        check({tag, " avail"}, 32'(mac_avail), 32'd1);
        mac_read(got, gl);
        check({tag, " data"}, got, d);
        check({tag, " last"}, 32'(gl), 32'(last));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        logic [7:0] rd;
        logic [31:0] d;
        logic l;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R9 / R8: reset state
        check("R9 reset mac_avail", 32'(mac_avail), 0);
        check("R9 reset rx_ready", 32'(rx_ready), 0);
        check("R9 reset tx_ready", 32'(tx_ready), 1);
        cfg_read(1'b0, rd); check("R8 reset thr read", 32'(rd), 32'h00);
        cfg_read(1'b1, rd); check("R8 reset start read", 32'(rd), 32'hA0);

        // R1: receive-ready table walk
        for (int i = 0; i < 8; i++) begin
            cfg_write(1'b0, {RX_VEC[i][11:8], 4'h0});
            rx_level = RX_VEC[i][7:1];
            tick(2);
            check($sformatf("R1 vec%0d rx_ready", i), 32'(rx_ready), 32'(RX_VEC[i][0]));
        end
        rx_level = '0;

        // R8: register access
        cfg_write(1'b0, 8'h5C);
        cfg_read(1'b0, rd); check("R8 thr readback", 32'(rd), 32'h5C);
        cfg_write(1'b1, 8'h37);
        cfg_read(1'b1, rd); check("R8 start readback", 32'(rd), 32'hA7);
        cfg_write(1'b1, 8'h00);

        // R4: S=0 offers a single word
        host_write(32'hA000_0001, 1'b0);
        check("R4 one word offered", 32'(mac_avail), 1);
        host_write(32'hA000_0002, 1'b1);
        expect_word("R4 w0", 32'hA000_0001, 1'b0);
        expect_word("R4 w1", 32'hA000_0002, 1'b1);
        check("R4 drained", 32'(mac_avail), 0);

        // R3: S=2 needs four words
        cfg_write(1'b1, 8'h02);
        for (int i = 0; i < 3; i++) host_write(32'hB000_0000 + 32'(i), 1'b0);
        check("R3 held at 3 of 4", 32'(mac_avail), 0);
        host_write(32'hB000_0003, 1'b0);
        check("R3 released at 4", 32'(mac_avail), 1);
        host_write(32'hB000_0004, 1'b1);
        for (int i = 0; i < 5; i++) expect_word("R3 drain", 32'hB000_0000 + 32'(i), i == 4);

        // R5: release point captured at the first word
        cfg_write(1'b1, 8'h03);
        host_write(32'hC000_0000, 1'b0);
        cfg_write(1'b1, 8'h01);
        for (int i = 1; i < 5; i++) host_write(32'hC000_0000 + 32'(i), 1'b0);
        check("R5 held at 5 of captured 6", 32'(mac_avail), 0);
        host_write(32'hC000_0005, 1'b0);
        check("R5 released at 6", 32'(mac_avail), 1);
        cfg_write(1'b1, 8'h0F);
        host_write(32'hC000_0006, 1'b0);
        check("R5 stays released", 32'(mac_avail), 1);
        host_write(32'hC000_0007, 1'b1);
        for (int i = 0; i < 8; i++) expect_word("R5 drain", 32'hC000_0000 + 32'(i), i == 7);

        // R6: short frame under S=15
        for (int i = 0; i < 2; i++) host_write(32'hD000_0000 + 32'(i), 1'b0);
        check("R6 held before end mark", 32'(mac_avail), 0);
        host_write(32'hD000_0002, 1'b1);
        check("R6 released by end mark", 32'(mac_avail), 1);
        for (int i = 0; i < 3; i++) expect_word("R6 drain", 32'hD000_0000 + 32'(i), i == 2);

        // R9: two frames back to back, order and end marks
        cfg_write(1'b1, 8'h00);
        host_write(32'hE000_0000, 1'b0);
        host_write(32'hE000_0001, 1'b1);
        host_write(32'hE100_0000, 1'b0);
        host_write(32'hE100_0001, 1'b0);
        host_write(32'hE100_0002, 1'b1);
        expect_word("R9 A0", 32'hE000_0000, 1'b0);
        expect_word("R9 A1", 32'hE000_0001, 1'b1);
        expect_word("R9 B0", 32'hE100_0000, 1'b0);
        expect_word("R9 B1", 32'hE100_0001, 1'b0);
        expect_word("R9 B2", 32'hE100_0002, 1'b1);

        // R2: transmit-ready at 16 and 15 free spaces (M=15)
        cfg_write(1'b0, 8'h0F);
        for (int i = 0; i < 48; i++) host_write(32'h100 + 32'(i), 1'b0);
        tick(2);
        check("R2 16 free", 32'(tx_ready), 1);
        host_write(32'h100 + 32'd48, 1'b0);
        tick(2);
        check("R2 15 free", 32'(tx_ready), 0);

        // R7: fill to 64, extra write dropped
        for (int i = 49; i < 64; i++) host_write(32'h100 + 32'(i), 1'b0);
        host_write(32'hDEAD_BEEF, 1'b0);
        for (int i = 0; i < 64; i++) expect_word("R7 full drain", 32'h100 + 32'(i), 1'b0);
        check("R7 empty after 64", 32'(mac_avail), 0);
        mac_read(d, l);
        host_write(32'h1234_5678, 1'b1);
        expect_word("R7 after empty read", 32'h1234_5678, 1'b1);
        check("R7 empty again", 32'(mac_avail), 0);

        // R7: simultaneous push and pop
        host_write(32'hF000_0000, 1'b0);
        host_write(32'hF000_0001, 1'b1);
        @(negedge clk);
        d = mac_rd_data;
        host_wr_en = 1'b1; host_wr_data = 32'hF100_0000; host_wr_last = 1'b1;
        mac_rd_en = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b0; host_wr_last = 1'b0; mac_rd_en = 1'b0;
        check("R7 simul pop data", d, 32'hF000_0000);
        expect_word("R7 simul rest0", 32'hF000_0001, 1'b1);
        expect_word("R7 simul rest1", 32'hF100_0000, 1'b1);
        check("R7 simul drained", 32'(mac_avail), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule